// File: doc/BRIEF.md
# Flagless Shift and Rotate Unit

This block is an integer execution slice that moves the bits of a source word without touching any condition flag. It performs four operations: rotate right by an immediate-style count, logical shift left, logical shift right, and arithmetic shift right. Each works on either a 32-bit or a 64-bit operand. The shift or rotate amount comes from the low byte of a count operand. Only the low 5 bits (32-bit size) or the low 6 bits (64-bit size) of that byte are used, so a count can never run past the operand width.

A 32-bit result is placed in the low half of the 64-bit result port, and the upper half is forced to zero. By default the result and its valid flag are captured in an output register, giving one cycle of latency. A parameter turns that register into a pass-through for purely combinational use. No flag is read, produced or forwarded.

Top module: `shx_unit`

## Requirements
- R1: With `op_sel` = 0 (rotate right), the result is the operand-size source rotated right by the masked count. Bits leaving position 0 re-enter at the top of the operand (bit 31 or bit 63).
- R2: With `op_sel` = 1 (shift left), bits move toward higher positions and the vacated low positions are filled with zeros.
- R3: With `op_sel` = 2 (logical shift right), bits move toward lower positions and the vacated high positions of the operand are filled with zeros.
- R4: With `op_sel` = 3 (arithmetic shift right), the vacated high positions are filled with the operand's sign bit. The sign bit is bit 31 when `wide_sel` = 0 and bit 63 when `wide_sel` = 1.
- R5: The effective count is `cnt_i` AND 0x1F when `wide_sel` = 0, and `cnt_i` AND 0x3F when `wide_sel` = 1. Higher count bits have no effect on the result.
- R6: When the effective count is zero, every operation returns the operand-size source unchanged.
- R7: When `wide_sel` = 0, `src_i[63:32]` has no effect and `res_o[63:32]` is zero.
- R8: With the output register enabled, `res_valid_o` equals `in_valid` of the previous cycle. `res_o` then shows the result for the inputs sampled at that edge.
- R9: While `in_valid` is low, `res_o` keeps its previous value.
- R10: While reset is asserted, `res_o` is zero and `res_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks the inputs as an operation to perform |
| op_sel | input | 2 | 0 rotate right, 1 shift left, 2 logical shift right, 3 arithmetic shift right |
| wide_sel | input | 1 | 1 selects 64-bit operand size, 0 selects 32-bit |
| src_i | input | 64 | Source word |
| cnt_i | input | 8 | Low byte of the count operand or immediate |
| res_o | output | 64 | Result word, zero-extended for 32-bit size |
| res_valid_o | output | 1 | Result valid |

## Verification
A fixed table covers each operation at both sizes. It uses counts of 0, 1, 4 and the width minus one, plus counts whose bits above the mask are set, so masking faults are separated from shifting faults. Sources with the sign bit set and sources with it clear tell the arithmetic shift apart from the logical one. Narrow sources with bit 63 set and bit 31 clear, or the reverse, expose a sign taken from the wrong position and upper source bits leaking into a 32-bit result. A pseudo-random sweep then checks every operation and size against a per-bit reference model. Directed checks cover the reset state, the one-cycle valid latency, and holding the result while no operation is presented.

// File: rtl/shx_pkg.sv
package shx_pkg;

  typedef enum logic [1:0] {
    OP_ROTR = 2'd0,
    OP_SHL  = 2'd1,
    OP_SHR  = 2'd2,
    OP_SAR  = 2'd3
  } shx_op_e;

endpackage

// File: rtl/shx_cnt_mask.sv
module shx_cnt_mask #(
  parameter int CNT_IN_W = 8,
  parameter int CW_WIDE  = 6,
  parameter int CW_NARR  = 5
) (
  input  logic                wide,
  input  logic [CNT_IN_W-1:0] cnt,
  output logic [CW_WIDE-1:0]  cnt_m,
  output logic                cnt_hi_seen
);

  function automatic logic [CW_WIDE-1:0] size_mask(input logic w);
    logic [CW_WIDE-1:0] m;
    for (int i = 0; i < CW_WIDE; i++) m[i] = w || (i < CW_NARR);
    return m;
  endfunction

  assign cnt_m       = cnt[CW_WIDE-1:0] & size_mask(wide);
  assign cnt_hi_seen = |cnt[CNT_IN_W-1:CW_WIDE];

endmodule

// File: rtl/shx_lane.sv
module shx_lane
  import shx_pkg::*;
#(
  parameter int W  = 64,
  localparam int CW = $clog2(W)
) (
  input  shx_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [CW-1:0]  c,
  output logic [W-1:0]   y
);

  function automatic logic [W-1:0] f_rotr(input logic [W-1:0] v, input logic [CW-1:0] s);
    logic [2*W-1:0] d;
    d = {v, v} >> s;
    return d[W-1:0];
  endfunction

  function automatic logic [W-1:0] f_shl(input logic [W-1:0] v, input logic [CW-1:0] s);
    return v << s;
  endfunction

  function automatic logic [W-1:0] f_shr(input logic [W-1:0] v, input logic [CW-1:0] s);
    return v >> s;
  endfunction

  function automatic logic [W-1:0] f_sar(input logic [W-1:0] v, input logic [CW-1:0] s);
    logic [W-1:0] r;
    r = $signed(v) >>> s;
    return r;
  endfunction

  always_comb begin
    unique case (op)
      OP_ROTR: y = f_rotr(a, c);
      OP_SHL:  y = f_shl(a, c);
      OP_SHR:  y = f_shr(a, c);
      default: y = f_sar(a, c);
    endcase
  end

endmodule

// File: rtl/shx_out_stage.sv
module shx_out_stage #(
  parameter int DATA_W  = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q,
  output logic              q_valid
);

  generate
    if (OUT_REG) begin : g_reg
      logic [DATA_W-1:0] q_r;
      logic              v_r;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q_r <= '0;
          v_r <= 1'b0;
        end else begin
          v_r <= in_valid;
          if (in_valid) q_r <= d;
        end
      end

      assign q       = q_r;
      assign q_valid = v_r;

      // R8
      valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid == $past(in_valid));

      // R8
      data_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> q == $past(d));

      // R9
      hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(q));
    end else begin : g_comb
      assign q       = d;
      assign q_valid = in_valid;

      // R8
      valid_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid == in_valid);
    end
  endgenerate

endmodule

// File: rtl/shx_unit.sv
module shx_unit
  import shx_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int CNT_IN_W = 8,
  parameter bit OUT_REG  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          op_sel,
  input  logic                wide_sel,
  input  logic [DATA_W-1:0]   src_i,
  input  logic [CNT_IN_W-1:0] cnt_i,
  output logic [DATA_W-1:0]   res_o,
  output logic                res_valid_o
);

  localparam int CW_WIDE = $clog2(DATA_W);
  localparam int CW_NARR = $clog2(NARROW_W);
  localparam int N_LANES = 2;

  shx_op_e             op;
  logic [CW_WIDE-1:0]  cnt_m;
  logic                cnt_hi_seen;
  logic [DATA_W-1:0]   lane_res [N_LANES];
  logic [DATA_W-1:0]   dp_res;
  logic [DATA_W-1:0]   src_sized;
  logic                cnt_zero;

  assign op = shx_op_e'(op_sel);

  shx_cnt_mask #(
    .CNT_IN_W (CNT_IN_W),
    .CW_WIDE  (CW_WIDE),
    .CW_NARR  (CW_NARR)
  ) u_mask (
    .wide        (wide_sel),
    .cnt         (cnt_i),
    .cnt_m       (cnt_m),
    .cnt_hi_seen (cnt_hi_seen)
  );

  // lane 0 is the narrow size, lane 1 the wide size
  generate
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      localparam int LW  = (g == 0) ? NARROW_W : DATA_W;
      localparam int LCW = $clog2(LW);
      logic [LW-1:0] y;

      shx_lane #(.W(LW)) u_lane (
        .op (op),
        .a  (src_i[LW-1:0]),
        .c  (cnt_m[LCW-1:0]),
        .y  (y)
      );

      assign lane_res[g] = DATA_W'(y);
    end
  endgenerate

  assign dp_res    = wide_sel ? lane_res[1] : lane_res[0];
  assign src_sized = wide_sel ? src_i : DATA_W'(src_i[NARROW_W-1:0]);
  assign cnt_zero  = (cnt_m == '0);

  shx_out_stage #(
    .DATA_W  (DATA_W),
    .OUT_REG (OUT_REG)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .d        (dp_res),
    .q        (res_o),
    .q_valid  (res_valid_o)
  );

  // R7
  narrow_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_sel |-> dp_res[DATA_W-1:NARROW_W] == '0);

  // R6
  zero_cnt_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_zero |-> dp_res == src_sized);

  // R5
  cnt_hi_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hi_seen && cnt_zero) |-> dp_res == src_sized);

  // R4
  sar_sign_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SAR && wide_sel) |-> dp_res[DATA_W-1] == src_i[DATA_W-1]);

  // R4
  sar_sign_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SAR && !wide_sel) |-> dp_res[NARROW_W-1] == src_i[NARROW_W-1]);

  // R2
  shl_low_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHL && !cnt_zero) |-> dp_res[0] == 1'b0);

  // R3
  shr_high_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHR && !cnt_zero && wide_sel) |-> dp_res[DATA_W-1] == 1'b0);

  // R1
  rotr_popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_ROTR |-> $countones(dp_res) == $countones(src_sized));

endmodule

// File: tb/tb_shx_unit.sv
module tb_shx_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op_sel;
  logic        wide_sel;
  logic [63:0] src_i;
  logic [7:0]  cnt_i;
  logic [63:0] res_o;
  logic        res_valid_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  shx_unit dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_sel      (op_sel),
    .wide_sel    (wide_sel),
    .src_i       (src_i),
    .cnt_i       (cnt_i),
    .res_o       (res_o),
    .res_valid_o (res_valid_o)
  );

  // per-bit reference built from the requirements
  function automatic logic [63:0] ref_model(input logic [1:0] op, input logic w,
                                            input logic [63:0] s, input logic [7:0] c);
    int width;
    int m;
    logic [63:0] r;
    width = w ? 64 : 32;
    m = int'(c) % width;
    r = '0;
    for (int i = 0; i < width; i++) begin
      case (op)
        2'd0: r[i] = s[(i + m) % width];
        2'd1: r[i] = (i >= m) ? s[i - m] : 1'b0;
        2'd2: r[i] = (i + m < width) ? s[i + m] : 1'b0;
        default: r[i] = (i + m < width) ? s[i + m] : s[width - 1];
      endcase
    end
    return r;
  endfunction

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [1:0] op, input logic w, input logic [63:0] s,
                         input logic [7:0] c, input string tag);
    @(negedge clk);
    op_sel = op; wide_sel = w; src_i = s; cnt_i = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, res_o, ref_model(op, w, s, c));
    chk({tag, " R8 valid"}, {63'd0, res_valid_o}, 64'd1);
  endtask

  localparam int NV = 12;
  localparam logic [1:0]  T_OP  [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd2,
                                          2'd2, 2'd3, 2'd3, 2'd3, 2'd3, 2'd1};
  localparam logic        T_W   [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
                                          1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [63:0] T_SRC [NV] = '{
    64'h0123_4567_89AB_CDEF, 64'hDEAD_BEEF_0000_0001, 64'hFFFF_0000_8000_0001,
    64'h0000_0000_0000_0003, 64'hAAAA_AAAA_1234_5678, 64'h8000_0000_0000_00F0,
    64'h0000_0000_8000_0000, 64'hF000_0000_0000_0000, 64'h0000_0000_8000_0000,
    64'hFFFF_FFFF_7FFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0};
  localparam logic [7:0]  T_CNT [NV] = '{8'h04, 8'h40, 8'h21, 8'h3F, 8'h20, 8'hC4,
                                          8'h1F, 8'h08, 8'h04, 8'h03, 8'h3F, 8'h80};

  initial begin
    #(4ns * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] seed;
    logic [63:0] held;
    rst_n = 1'b0; in_valid = 1'b0; op_sel = 2'd0; wide_sel = 1'b0;
    src_i = '0; cnt_i = '0;

    // R10: drive an operation during reset; outputs stay cleared
    repeat (2) @(negedge clk);
    in_valid = 1'b1; src_i = 64'hFFFF_FFFF_FFFF_FFFF; wide_sel = 1'b1;
    @(negedge clk);
    chk("R10 reset result", res_o, 64'd0);
    chk("R10 reset valid", {63'd0, res_valid_o}, 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: R1 to R4 by op; masked counts (R5), zero count (R6), narrow (R7)
    for (int i = 0; i < NV; i++) begin
      run_vec(T_OP[i], T_W[i], T_SRC[i], T_CNT[i], op_tag(T_OP[i]));
    end

    // R6: zero effective count on every op returns source
    for (int op = 0; op < 4; op++) begin
      run_vec(2'(op), 1'b1, 64'hC3A5_0F1E_9876_5432, 8'h00, "R6 zero count");
      chk("R6 zero count wide", res_o, 64'hC3A5_0F1E_9876_5432);
    end

    // R5: high count bits ignored, narrow 0x25 behaves as 5
    run_vec(2'd2, 1'b0, 64'h0000_0000_F000_0000, 8'h25, "R5 mask narrow");
    chk("R5 mask narrow literal", res_o, 64'h0000_0000_0780_0000);

    // R4: narrow sign from bit 31, not 63
    run_vec(2'd3, 1'b0, 64'h0000_0000_8000_0000, 8'h04, "R4 narrow sign");
    chk("R4 narrow sign literal", res_o, 64'h0000_0000_F800_0000);

    // R7: upper source ignored and result upper half zero
    run_vec(2'd0, 1'b0, 64'hFFFF_FFFF_0000_0001, 8'h01, "R7 narrow rotate");
    chk("R7 narrow rotate literal", res_o, 64'h0000_0000_8000_0000);

    // R9: idle cycles with changing inputs do not disturb result
    held = res_o;
    @(negedge clk);
    src_i = 64'h5555_5555_5555_5555; cnt_i = 8'h07; op_sel = 2'd1;
    repeat (3) @(negedge clk);
    chk("R9 hold", res_o, held);
    chk("R8 valid low when idle", {63'd0, res_valid_o}, 64'd0);

    // pseudo-random sweep over all ops and sizes
    seed = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 400; k++) begin
      seed ^= seed << 13;
      seed ^= seed >> 7;
      seed ^= seed << 17;
      run_vec(seed[1:0], seed[2], {seed[40:0], seed[63:41]} ^ 64'h0F0F_00FF_F0F0_FF00,
              seed[15:8], op_tag(seed[1:0]));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule